// File: doc/BRIEF.md
# Boot Mode Latch and Selector

This block decides, once per power-on, how the chip starts. It captures the two boot-mode pins and the GPIO configuration override pins on the first clock edge after the active-low power-on reset is released. From then on it holds that captured mode as a read-only status field. The captured mode, a fuse-select bit and a boot-configuration fuse word together pick one of two paths. The first is serial download. The second is boot from an external device, whose class is decoded from the effective configuration word.

The decision outputs settle on the edge that captures the pins. A one-cycle strobe on the following edge tells the boot sequencer it may read them. If the sequencer reports a failed attempt while the captured mode is internal boot, the block switches to serial download. It stays there until the next power-on reset. The fuse inputs are treated as static levels. All outputs are plain control and status pins. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `boot_path_select`

## Requirements
- R1: On the first rising clock edge after `por_n` goes high, `mode_pins` is captured and shown on `mode_stat`. Changes on `mode_pins` after that edge leave `mode_stat` and every decision output unchanged until `por_n` is asserted again.
- R2: A captured mode of 2'b01 (serial download) drives `path_download` high and `dev_class` to 0.
- R3: A captured mode of 2'b00 (fuse boot) with `fuse_sel` = 0 drives `path_download` high and `dev_class` to 0.
- R4: A captured mode of 2'b00 with `fuse_sel` = 1 sets `eff_cfg` to `fuse_cfg` and selects the external path. The GPIO override pins have no effect.
- R5: A captured mode of 2'b10 (internal boot) with `fuse_sel` = 0 sets `eff_cfg` to the value `gpio_cfg` had at the capture edge. Later changes on `gpio_cfg` are ignored.
- R6: A captured mode of 2'b10 with `fuse_sel` = 1 sets `eff_cfg` to `fuse_cfg`.
- R7: On the external path, `dev_class` is decoded from `eff_cfg[7:4]` as follows:
  - 0 → serial NOR (1)
  - 8 → serial NAND (2)
  - 2 → parallel NOR (3)
  - 4 → raw NAND (4)
  - 6 → SD/MMC (5)
  - 1 → SPI NOR/EEPROM (6)
- R8: A clock edge that sees `boot_fail` high, while the captured mode is 2'b10, switches to download from that edge on: `path_download` = 1 and `dev_class` = 0. This holds until reset. `boot_fail` has no effect in any other mode.
- R9: A captured mode of 2'b11 (reserved) drives `path_download` high and raises `mode_reserved`.
- R10: On the external path, a type code outside the R7 list raises `type_err`, drives `path_download` high and sets `dev_class` to 0.
- R11: `decide_valid` is high for exactly one cycle, starting at the second clock edge after reset release.
- R12: While `por_n` is low, the outputs take these values:
  - `path_download` = 1
  - `mode_stat`, `dev_class`, `eff_cfg`, `mode_reserved`, `type_err` and `decide_valid` = 0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous assert |
| mode_pins | input | 2 | Boot-mode pins |
| fuse_sel | input | 1 | Fuse-select bit |
| fuse_cfg | input | CFG_W | Boot-configuration fuse word |
| gpio_cfg | input | CFG_W | GPIO configuration override pins |
| boot_fail | input | 1 | Boot attempt failure report |
| mode_stat | output | 2 | Captured boot mode |
| path_download | output | 1 | 1 = serial download, 0 = external device boot |
| dev_class | output | 3 | Selected device class, 0 when downloading |
| eff_cfg | output | CFG_W | Effective boot-configuration word |
| mode_reserved | output | 1 | Captured mode is the reserved code |
| type_err | output | 1 | Unassigned device type code on the external path |
| decide_valid | output | 1 | One-cycle strobe: decision is stable |

## Verification
The mode status, the effective word, the path, the device class and both flags are due right after the first edge following reset release. The bench releases `por_n` at a falling edge and samples at the next falling edge. `decide_valid` is sampled after the second and third edges, so both its rise and its fall are seen. A `boot_fail` pulse is driven for one edge, then the path is checked at the next falling edge and again one cycle later to confirm it is sticky. Pin changes made after capture are checked at the same falling-edge points to confirm they have no effect.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;
  localparam int TYPE_W = 4;

  typedef enum logic [1:0] {
    MODE_FUSE = 2'b00,
    MODE_DL   = 2'b01,
    MODE_INT  = 2'b10,
    MODE_RSVD = 2'b11
  } boot_mode_e;

  typedef enum logic [2:0] {
    DEV_NONE   = 3'd0,
    DEV_SNOR   = 3'd1,
    DEV_SNAND  = 3'd2,
    DEV_PNOR   = 3'd3,
    DEV_RNAND  = 3'd4,
    DEV_SDMMC  = 3'd5,
    DEV_SPIROM = 3'd6
  } dev_class_e;
endpackage

// File: rtl/bootmode_capture.sv
module bootmode_capture #(
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [1:0]       mode_pins,
  input  logic [CFG_W-1:0] gpio_cfg,
  output logic             captured,
  output logic [1:0]       mode_q,
  output logic [CFG_W-1:0] gpio_q,
  output logic             valid
);
  logic strobe_done;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      captured    <= 1'b0;
      mode_q      <= 2'b00;
      gpio_q      <= '0;
      valid       <= 1'b0;
      strobe_done <= 1'b0;
    end else begin
      if (!captured) begin
        captured <= 1'b1;
        mode_q   <= mode_pins;
        gpio_q   <= gpio_cfg;
      end
      valid <= captured && !strobe_done;
      if (captured) strobe_done <= 1'b1;
    end
  end

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
    $past(captured) |-> $stable(mode_q) && $stable(gpio_q)); // R1

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
    valid |=> !valid); // R11

  AST_VALID_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!por_n)
    valid |-> captured); // R11
endmodule

// File: rtl/boot_cfg_mux.sv
module boot_cfg_mux
  import boot_sel_pkg::*;
#(
  parameter int CFG_W = 16
) (
  input  logic [1:0]       mode,
  input  logic             fuse_sel,
  input  logic [CFG_W-1:0] fuse_cfg,
  input  logic [CFG_W-1:0] gpio_q,
  output logic [CFG_W-1:0] cfg_o,
  output logic             ext_route
);
  always_comb begin
    cfg_o     = fuse_cfg;
    ext_route = 1'b0;
    unique case (boot_mode_e'(mode))
      MODE_FUSE: ext_route = fuse_sel;
      MODE_INT: begin
        ext_route = 1'b1;
        if (!fuse_sel) cfg_o = gpio_q;
      end
      MODE_DL, MODE_RSVD: ext_route = 1'b0;
      default: ext_route = 1'b0;
    endcase
  end
endmodule

// File: rtl/boot_dev_decode.sv
module boot_dev_decode
  import boot_sel_pkg::*;
#(
  parameter int CFG_W    = 16,
  parameter int TYPE_LSB = 4
) (
  input  logic [CFG_W-1:0] cfg,
  output dev_class_e       class_o,
  output logic             code_ok
);
  logic [TYPE_W-1:0] code;
  assign code = cfg[TYPE_LSB +: TYPE_W];

  always_comb begin
    code_ok = 1'b1;
    case (code)
      4'd0:    class_o = DEV_SNOR;
      4'd8:    class_o = DEV_SNAND;
      4'd2:    class_o = DEV_PNOR;
      4'd4:    class_o = DEV_RNAND;
      4'd6:    class_o = DEV_SDMMC;
      4'd1:    class_o = DEV_SPIROM;
      default: begin
        class_o = DEV_NONE;
        code_ok = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/boot_path_select.sv
module boot_path_select
  import boot_sel_pkg::*;
#(
  parameter int CFG_W    = 16,
  parameter int TYPE_LSB = 4
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [1:0]       mode_pins,
  input  logic             fuse_sel,
  input  logic [CFG_W-1:0] fuse_cfg,
  input  logic [CFG_W-1:0] gpio_cfg,
  input  logic             boot_fail,
  output logic [1:0]       mode_stat,
  output logic             path_download,
  output logic [2:0]       dev_class,
  output logic [CFG_W-1:0] eff_cfg,
  output logic             mode_reserved,
  output logic             type_err,
  output logic             decide_valid
);
  logic             captured;
  logic [1:0]       mode_q;
  logic [CFG_W-1:0] gpio_q;
  logic [CFG_W-1:0] cfg_sel;
  logic             ext_route;
  dev_class_e       dec_class;
  logic             code_ok;
  logic             fail_q;

  bootmode_capture #(.CFG_W(CFG_W)) cap_i (
    .clk(clk), .por_n(por_n), .mode_pins(mode_pins), .gpio_cfg(gpio_cfg),
    .captured(captured), .mode_q(mode_q), .gpio_q(gpio_q), .valid(decide_valid)
  );

  boot_cfg_mux #(.CFG_W(CFG_W)) mux_i (
    .mode(mode_q), .fuse_sel(fuse_sel), .fuse_cfg(fuse_cfg), .gpio_q(gpio_q),
    .cfg_o(cfg_sel), .ext_route(ext_route)
  );

  boot_dev_decode #(.CFG_W(CFG_W), .TYPE_LSB(TYPE_LSB)) dec_i (
    .cfg(cfg_sel), .class_o(dec_class), .code_ok(code_ok)
  );

  // Sticky fallback after a failed internal boot attempt
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) fail_q <= 1'b0;
    else if (captured && mode_q == MODE_INT && boot_fail) fail_q <= 1'b1;
  end

  assign mode_stat     = mode_q;
  assign eff_cfg       = captured ? cfg_sel : '0;
  assign mode_reserved = captured && (mode_q == MODE_RSVD);
  assign type_err      = captured && ext_route && !code_ok;
  assign path_download = !captured || !ext_route || !code_ok || fail_q;
  assign dev_class     = path_download ? DEV_NONE : dec_class;

  AST_DL_MODE: assert property (@(posedge clk) disable iff (!por_n)
    (captured && mode_q == MODE_DL) |-> path_download); // R2

  AST_FUSE_NOSEL_DL: assert property (@(posedge clk) disable iff (!por_n)
    (captured && mode_q == MODE_FUSE && !fuse_sel) |-> path_download && dev_class == 3'd0); // R3

  AST_FAIL_FALLBACK: assert property (@(posedge clk) disable iff (!por_n)
    (captured && mode_q == MODE_INT && boot_fail) |=> path_download); // R8

  AST_RSVD_DL: assert property (@(posedge clk) disable iff (!por_n)
    mode_reserved |-> path_download); // R9

  AST_TYPE_ERR_DL: assert property (@(posedge clk) disable iff (!por_n)
    type_err |-> path_download && dev_class == 3'd0); // R10

  AST_CLASS_ONLY_EXT: assert property (@(posedge clk) disable iff (!por_n)
    (dev_class != 3'd0) |-> !path_download); // R7
endmodule

// File: tb/boot_path_select_tb_top.sv
`timescale 1ns/1ps
module boot_path_select_tb_top;
  localparam int CFG_W = 16;

  logic             clk = 1'b0;
  logic             por_n = 1'b0;
  logic [1:0]       mode_pins = 2'b00;
  logic             fuse_sel = 1'b0;
  logic [CFG_W-1:0] fuse_cfg = '0;
  logic [CFG_W-1:0] gpio_cfg = '0;
  logic             boot_fail = 1'b0;
  logic [1:0]       mode_stat;
  logic             path_download;
  logic [2:0]       dev_class;
  logic [CFG_W-1:0] eff_cfg;
  logic             mode_reserved;
  logic             type_err;
  logic             decide_valid;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #2.5 clk = ~clk;

  boot_path_select #(.CFG_W(CFG_W)) dut_i (
    .clk(clk), .por_n(por_n), .mode_pins(mode_pins), .fuse_sel(fuse_sel),
    .fuse_cfg(fuse_cfg), .gpio_cfg(gpio_cfg), .boot_fail(boot_fail),
    .mode_stat(mode_stat), .path_download(path_download), .dev_class(dev_class),
    .eff_cfg(eff_cfg), .mode_reserved(mode_reserved), .type_err(type_err),
    .decide_valid(decide_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_class(input logic [3:0] code);
    case (code)
      4'd0: return 3'd1;
      4'd8: return 3'd2;
      4'd2: return 3'd3;
      4'd4: return 3'd4;
      4'd6: return 3'd5;
      4'd1: return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int c = 0; c < 16; c++) begin
          logic [CFG_W-1:0] g, f, src;
          logic ext, ok, dl;
          g = {8'h3C, 4'(c), 4'h1};
          f = {8'hC3, 4'(c + 3), 4'h9};
          ext = (m == 0 && s == 1) || (m == 2);
          src = (m == 2 && s == 0) ? g : f;
          ok  = (src[7:4] inside {4'd0, 4'd1, 4'd2, 4'd4, 4'd6, 4'd8});
          dl  = !ext || !ok;

          @(negedge clk);
          por_n = 1'b0;
          mode_pins = 2'(m); fuse_sel = s[0]; gpio_cfg = g; fuse_cfg = f;
          @(negedge clk);
          // R12 reset state
          check("R12 path", path_download, 1);
          check("R12 mode", mode_stat, 0);
          check("R12 class", dev_class, 0);
          check("R12 cfg", eff_cfg, 0);
          check("R12 flags", {mode_reserved, type_err, decide_valid}, 0);
          por_n = 1'b1;
          @(negedge clk);
          check("R1 mode", mode_stat, m);
          check("R11 low at capture", decide_valid, 0);
          check(m == 1 ? "R2 path" : (m == 0 && s == 0) ? "R3 path" : "R10 path",
                path_download, dl);
          check("R7 class", dev_class, dl ? 3'd0 : exp_class(src[7:4]));
          if (m == 2 && s == 0) check("R5 cfg", eff_cfg, g);
          else if (m == 2) check("R6 cfg", eff_cfg, f);
          else if (m == 0 && s == 1) check("R4 cfg", eff_cfg, f);
          check("R9 reserved", mode_reserved, m == 3);
          check("R10 type_err", type_err, ext && !ok);
          // change pins after capture
          mode_pins = ~mode_pins;
          gpio_cfg  = ~g;
          @(negedge clk);
          check("R11 strobe", decide_valid, 1);
          check("R1 frozen mode", mode_stat, m);
          check("R5 gpio ignored", eff_cfg, src);
          check("R1 frozen path", path_download, dl);
          @(negedge clk);
          check("R11 strobe end", decide_valid, 0);
          boot_fail = 1'b1;
          @(negedge clk);
          boot_fail = 1'b0;
          check("R8 fallback", path_download, (m == 2) ? 1'b1 : dl);
          @(negedge clk);
          check("R8 sticky", path_download, (m == 2) ? 1'b1 : dl);
          check("R8 class", dev_class, (m == 2 || dl) ? 3'd0 : exp_class(src[7:4]));
        end
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule